// File: doc/BRIEF.md
# Bus-Width Burst Request Splitter

This block takes one memory access from a load/store unit and turns it into the bus bursts that a bus sequencer runs. An access is 1, 2, 4, 8, 12 or 16 bytes long. The data region it targets is 8, 16 or 32 bits wide. No burst may carry more than four data transfers, whatever the bus width. A wide access to a narrow region therefore leaves as several bursts back to back. The same access on a 32-bit region usually fits in one burst.

For each burst the block presents a start address and a transfer count on a valid/ready output. The block accepts only one access at a time. It returns to the idle state when the final burst is taken, and pulses a completion flag at that point. Before any burst is produced, the start address is checked against the alignment rule for the access size and the region width. A failing access is answered with a one-cycle error pulse and produces no bursts. Data steering and bus signal timing belong to other blocks.

Top module: `bsplit_top`

## Requirements
- R1: Size codes are 0 byte, 1 halfword, 2 word, 3 double word (8 bytes), 4 triple word (12 bytes) and 5 quad word (16 bytes). Width codes are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Out of reset, `req_ready_o` is 1 and `brst_valid_o`, `done_o` and `err_o` are 0.
- R2: A burst's transfer count is the number of bus-width beats the remaining bytes need, limited to MAX_BEATS (4). It is never 0.
- R3: Each burst after the first starts at the previous start address plus the bytes that burst moved: MAX_BEATS × bus bytes for every burst except the last.
- R4: The first burst is valid in the cycle after the request handshake, and its address equals the request address.
- R5: On a 32-bit region, a triple-word or quad-word access must have address bits 3:0 equal to 0. A double-word access must have bits 2:0 equal to 0. A word access must have bits 1:0 equal to 0.
- R6: On every width, a halfword must have bit 0 equal to 0. A word or larger access must have bits 1:0 equal to 0. Width code 3 and size codes 6 and 7 are always invalid.
- R7: A request that breaks R5 or R6 is accepted. It raises `err_o` for exactly one cycle, in the cycle after acceptance, and produces no burst and no `done_o`.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last burst's handshake. `req_ready_o` is high in that same cycle.
- R9: `req_ready_o` stays low from the cycle after a valid request is accepted until the last burst is handed off. A request offered while the block is busy is ignored.
- R10: While `brst_valid_o` is high and `brst_ready_i` is low, the burst address and transfer count hold steady.
- R11: An active-low reset during a burst sequence abandons that sequence and returns the block to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_addr_i | input | ADDR_W | Byte start address of the access |
| req_size_i | input | 3 | Access size code (R1) |
| req_width_i | input | 2 | Data-region width code (R1) |
| brst_valid_o | output | 1 | Burst descriptor present |
| brst_ready_i | input | 1 | Sequencer takes the burst |
| brst_addr_o | output | ADDR_W | Burst start byte address |
| brst_beats_o | output | $clog2(MAX_BEATS+1) | Data transfers in this burst |
| done_o | output | 1 | One-cycle pulse after the last burst is taken |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench builds the block with ADDR_W = 16 and keeps MAX_BEATS at 4. The narrow address width lets one vector sit at the top of the address space, where every burst address can be predicted exactly, and lets the expected results be written as short constants. Keeping the four-beat limit means the byte-wide, halfword-wide and word-wide cases produce the multi-burst splits of four, two and one bursts, including a shortened last burst of a triple word on a 16-bit region.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

  localparam logic [2:0] SZ_BYTE  = 3'd0;
  localparam logic [2:0] SZ_HALF  = 3'd1;
  localparam logic [2:0] SZ_WORD  = 3'd2;
  localparam logic [2:0] SZ_DWORD = 3'd3;
  localparam logic [2:0] SZ_TWORD = 3'd4;
  localparam logic [2:0] SZ_QWORD = 3'd5;

  localparam logic [1:0] WD_8  = 2'd0;
  localparam logic [1:0] WD_16 = 2'd1;
  localparam logic [1:0] WD_32 = 2'd2;

  // Remaining-byte counter width: a quad word is 16 bytes.
  localparam int REM_W = 5;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } seq_state_e;

  // Bytes moved by an access of the given size code; 0 for an unused code.
  function automatic logic [REM_W-1:0] size_bytes(input logic [2:0] sz);
    case (sz)
      SZ_BYTE:  return REM_W'(1);
      SZ_HALF:  return REM_W'(2);
      SZ_WORD:  return REM_W'(4);
      SZ_DWORD: return REM_W'(8);
      SZ_TWORD: return REM_W'(12);
      SZ_QWORD: return REM_W'(16);
      default:  return REM_W'(0);
    endcase
  endfunction

  // Alignment legality of a start address, judged on its four low bits.
  function automatic logic align_ok(input logic [3:0] lo,
                                    input logic [2:0] sz,
                                    input logic [1:0] wd);
    logic wide_bus;
    wide_bus = (wd == WD_32);
    if (wd == 2'd3) return 1'b0;
    case (sz)
      SZ_BYTE:  return 1'b1;
      SZ_HALF:  return (lo[0] == 1'b0);
      SZ_WORD:  return (lo[1:0] == 2'b00);
      SZ_DWORD: return (lo[1:0] == 2'b00) && (!wide_bus || (lo[2] == 1'b0));
      SZ_TWORD,
      SZ_QWORD: return (lo[1:0] == 2'b00) && (!wide_bus || (lo[3:2] == 2'b00));
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bsplit_align.sv
module bsplit_align
  import bsplit_pkg::*;
(
  input  logic [3:0]       addr_lo_i,
  input  logic [2:0]       size_i,
  input  logic [1:0]       width_i,
  output logic             legal_o,
  output logic [REM_W-1:0] nbytes_o
);

  always_comb begin
    nbytes_o = size_bytes(size_i);
    legal_o  = align_ok(addr_lo_i, size_i, width_i) && (nbytes_o != '0);
  end

endmodule

// File: rtl/bsplit_chunk.sv
module bsplit_chunk
  import bsplit_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  parameter int BEAT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic [1:0]        width_i,
  output logic [REM_W-1:0]  bytes_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              last_o
);

  // Bytes per beat is a power of two picked by the width code, so the
  // ceiling division below is an add and a shift.
  always_comb begin
    int r;
    int cap;
    int b;
    r       = int'(rem_i);
    cap     = MAX_BEATS << width_i;
    b       = (r < cap) ? r : cap;
    bytes_o = REM_W'(b);
    beats_o = BEAT_W'((b + (1 << width_i) - 1) >> width_i);
    last_o  = (b == r);
  end

endmodule

// File: rtl/bsplit_seq.sv
module bsplit_seq
  import bsplit_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 4,
  parameter int BEAT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_width_i,
  input  logic              req_legal_i,
  input  logic [REM_W-1:0]  req_nbytes_i,
  output logic [REM_W-1:0]  rem_o,
  output logic [1:0]        width_o,
  input  logic [REM_W-1:0]  chunk_bytes_i,
  input  logic [BEAT_W-1:0] chunk_beats_i,
  input  logic              chunk_last_i,
  output logic              brst_valid_o,
  input  logic              brst_ready_i,
  output logic [ADDR_W-1:0] brst_addr_o,
  output logic [BEAT_W-1:0] brst_beats_o,
  output logic              done_o,
  output logic              err_o
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;
  logic [1:0]        wd_q;
  logic              done_q;
  logic              err_q;

  // Named events for the checks below.
  logic req_fire;
  logic accept_good;
  logic accept_bad;
  logic burst_fire;
  logic last_fire;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign req_fire     = req_valid_i && req_ready_o;
  assign accept_good  = req_fire && req_legal_i;
  assign accept_bad   = req_fire && !req_legal_i;
  assign brst_valid_o = (state_q == ST_BURST);
  assign burst_fire   = brst_valid_o && brst_ready_i;
  assign last_fire    = burst_fire && chunk_last_i;

  assign brst_addr_o  = addr_q;
  assign brst_beats_o = chunk_beats_i;
  assign rem_o        = rem_q;
  assign width_o      = wd_q;
  assign done_o       = done_q;
  assign err_o        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      wd_q    <= WD_8;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= accept_bad;
      case (state_q)
        ST_IDLE: begin
          if (accept_good) begin
            addr_q  <= req_addr_i;
            rem_q   <= req_nbytes_i;
            wd_q    <= req_width_i;
            state_q <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (burst_fire) begin
            addr_q <= addr_q + ADDR_W'(chunk_bytes_i);
            rem_q  <= rem_q - chunk_bytes_i;
            if (chunk_last_i) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: transfer count of a presented burst lies in 1..MAX_BEATS.
  p_beats_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    brst_valid_o |-> (brst_beats_o != '0) && (int'(brst_beats_o) <= MAX_BEATS));

  // R3: a non-final handoff advances the address by the bytes moved.
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_fire && !chunk_last_i) |=>
      (brst_valid_o && brst_addr_o == $past(brst_addr_o) + ADDR_W'($past(chunk_bytes_i))));

  // R4: a legal request yields its first burst at its own address next cycle.
  p_first_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_good |=> (brst_valid_o && brst_addr_o == $past(req_addr_i)));

  // R7: a rejected request pulses err and opens no burst.
  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (err_o && !brst_valid_o && !done_o));

  // R8: completion only follows the handoff of a final burst.
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(last_fire) && req_ready_o));

  // R9: no new request while a sequence has bursts left.
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_fire && !chunk_last_i) |=> !req_ready_o);

  // R10: a stalled burst keeps its descriptor.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_valid_o && !brst_ready_i) |=>
      (brst_valid_o && $stable(brst_addr_o) && $stable(brst_beats_o)));

endmodule

// File: rtl/bsplit_top.sv
module bsplit_top
  import bsplit_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 4,
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  input  logic [1:0]        req_width_i,
  output logic              brst_valid_o,
  input  logic              brst_ready_i,
  output logic [ADDR_W-1:0] brst_addr_o,
  output logic [BEAT_W-1:0] brst_beats_o,
  output logic              done_o,
  output logic              err_o
);

  logic             req_legal;
  logic [REM_W-1:0] req_nbytes;
  logic [REM_W-1:0] rem;
  logic [1:0]       width_q;
  logic [REM_W-1:0] chunk_bytes;
  logic [BEAT_W-1:0] chunk_beats;
  logic             chunk_last;

  bsplit_align u_align (
    .addr_lo_i (req_addr_i[3:0]),
    .size_i    (req_size_i),
    .width_i   (req_width_i),
    .legal_o   (req_legal),
    .nbytes_o  (req_nbytes)
  );

  bsplit_chunk #(
    .MAX_BEATS (MAX_BEATS),
    .BEAT_W    (BEAT_W)
  ) u_chunk (
    .rem_i     (rem),
    .width_i   (width_q),
    .bytes_o   (chunk_bytes),
    .beats_o   (chunk_beats),
    .last_o    (chunk_last)
  );

  bsplit_seq #(
    .ADDR_W    (ADDR_W),
    .MAX_BEATS (MAX_BEATS),
    .BEAT_W    (BEAT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_addr_i    (req_addr_i),
    .req_width_i   (req_width_i),
    .req_legal_i   (req_legal),
    .req_nbytes_i  (req_nbytes),
    .rem_o         (rem),
    .width_o       (width_q),
    .chunk_bytes_i (chunk_bytes),
    .chunk_beats_i (chunk_beats),
    .chunk_last_i  (chunk_last),
    .brst_valid_o  (brst_valid_o),
    .brst_ready_i  (brst_ready_i),
    .brst_addr_o   (brst_addr_o),
    .brst_beats_o  (brst_beats_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

endmodule

// File: tb/bsplit_top_tb.sv
module bsplit_top_tb;

  localparam int AW = 16;
  localparam int MB = 4;
  localparam int BW = $clog2(MB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_size = '0;
  logic [1:0]    req_width = '0;
  logic          brst_valid;
  logic          brst_ready = 1'b0;
  logic [AW-1:0] brst_addr;
  logic [BW-1:0] brst_beats;
  logic          done;
  logic          err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bsplit_top #(.ADDR_W(AW), .MAX_BEATS(MB)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_addr_i   (req_addr),
    .req_size_i   (req_size),
    .req_width_i  (req_width),
    .brst_valid_o (brst_valid),
    .brst_ready_i (brst_ready),
    .brst_addr_o  (brst_addr),
    .brst_beats_o (brst_beats),
    .done_o       (done),
    .err_o        (err)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [2:0]  sz;
    logic [1:0]  wd;
    logic        bad;
    logic [2:0]  nb;
    logic [2:0]  fb;
    logic [2:0]  lb;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{16'h0100, 3'd5, 2'd0, 1'b0, 3'd4, 3'd4, 3'd4},
    '{16'h0100, 3'd5, 2'd2, 1'b0, 3'd1, 3'd4, 3'd4},
    '{16'h0200, 3'd4, 2'd2, 1'b0, 3'd1, 3'd3, 3'd3},
    '{16'h0204, 3'd4, 2'd2, 1'b1, 3'd0, 3'd0, 3'd0},
    '{16'h0308, 3'd3, 2'd2, 1'b0, 3'd1, 3'd2, 3'd2},
    '{16'h0304, 3'd3, 2'd2, 1'b1, 3'd0, 3'd0, 3'd0},
    '{16'h040C, 3'd2, 2'd2, 1'b0, 3'd1, 3'd1, 3'd1},
    '{16'h0010, 3'd5, 2'd1, 1'b0, 3'd2, 3'd4, 3'd4},
    '{16'h0020, 3'd4, 2'd1, 1'b0, 3'd2, 3'd4, 3'd2},
    '{16'h0034, 3'd4, 2'd0, 1'b0, 3'd3, 3'd4, 3'd4},
    '{16'h0007, 3'd0, 2'd2, 1'b0, 3'd1, 3'd1, 3'd1},
    '{16'h0006, 3'd1, 2'd0, 1'b0, 3'd1, 3'd2, 3'd2},
    '{16'h0005, 3'd1, 2'd1, 1'b1, 3'd0, 3'd0, 3'd0},
    '{16'h0002, 3'd2, 2'd0, 1'b1, 3'd0, 3'd0, 3'd0},
    '{16'h0104, 3'd3, 2'd1, 1'b0, 3'd1, 3'd4, 3'd4},
    '{16'h0000, 3'd5, 2'd3, 1'b1, 3'd0, 3'd0, 3'd0},
    '{16'h0000, 3'd6, 2'd2, 1'b1, 3'd0, 3'd0, 3'd0},
    '{16'hFFF0, 3'd5, 2'd0, 1'b0, 3'd4, 3'd4, 3'd4},
    '{16'h0006, 3'd1, 2'd2, 1'b0, 3'd1, 3'd1, 3'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
      finish_run();
    end
  end

  // Offers one request and follows every burst it produces with ready held high.
  task automatic run_vec(input vec_t v, input int idx);
    int step;
    step = 4 << v.wd;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", $sformatf("vec %0d idle ready", idx), req_ready, 1);
    req_valid = 1'b1;
    req_addr  = v.addr;
    req_size  = v.sz;
    req_width = v.wd;
    brst_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.bad) begin
      chk(err == 1'b1 && brst_valid == 1'b0, "R7", $sformatf("vec %0d err pulse", idx),
          {err, brst_valid}, 2'b10);
      @(negedge clk);
      chk(err == 1'b0 && done == 1'b0 && brst_valid == 1'b0, "R7",
          $sformatf("vec %0d quiet after err", idx), {err, done, brst_valid}, 0);
    end else begin
      for (int k = 0; k < int'(v.nb); k++) begin
        int exp_b;
        exp_b = (k == int'(v.nb) - 1) ? int'(v.lb) : int'(v.fb);
        chk(brst_valid == 1'b1, "R4", $sformatf("vec %0d burst %0d valid", idx, k),
            brst_valid, 1);
        chk(brst_addr == AW'(int'(v.addr) + k * step), "R3",
            $sformatf("vec %0d burst %0d addr", idx, k), brst_addr, AW'(int'(v.addr) + k * step));
        chk(int'(brst_beats) == exp_b, "R2", $sformatf("vec %0d burst %0d beats", idx, k),
            brst_beats, exp_b);
        chk(req_ready == 1'b0, "R9", $sformatf("vec %0d busy", idx), req_ready, 0);
        @(negedge clk);
      end
      chk(done == 1'b1 && brst_valid == 1'b0 && req_ready == 1'b1, "R8",
          $sformatf("vec %0d done", idx), {done, brst_valid, req_ready}, 3'b101);
      @(negedge clk);
      chk(done == 1'b0, "R8", $sformatf("vec %0d done single", idx), done, 0);
    end
    brst_ready = 1'b0;
  endtask

  initial begin
    // R1: reset state
    #20;
    chk(req_ready == 1'b1 && brst_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1",
        "reset outputs", {req_ready, brst_valid, done, err}, 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 from the vector table
    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R10: stall a quad word on a 16-bit region; R9: a request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0040; req_size = 3'd5; req_width = 2'd1;
    @(negedge clk);
    req_addr = 16'h0080; req_size = 3'd0; req_width = 2'd2;
    for (int s = 0; s < 3; s++) begin
      chk(brst_valid && brst_addr == 16'h0040 && brst_beats == 3'd4, "R10",
          $sformatf("stall %0d first burst", s), brst_addr, 16'h0040);
      chk(req_ready == 1'b0, "R9", "busy during stall", req_ready, 0);
      @(negedge clk);
    end
    brst_ready = 1'b1;
    @(negedge clk);
    brst_ready = 1'b0;
    req_valid = 1'b0;
    for (int s = 0; s < 2; s++) begin
      chk(brst_valid && brst_addr == 16'h0048 && brst_beats == 3'd4, "R10",
          $sformatf("stall %0d second burst", s), brst_addr, 16'h0048);
      @(negedge clk);
    end
    brst_ready = 1'b1;
    @(negedge clk);
    brst_ready = 1'b0;
    chk(done == 1'b1, "R8", "done after stalls", done, 1);
    @(negedge clk);
    chk(brst_valid == 1'b0 && err == 1'b0, "R9", "busy request left no burst",
        {brst_valid, err}, 0);

    // R11: reset in the middle of a sequence
    req_valid = 1'b1; req_addr = 16'h0100; req_size = 3'd5; req_width = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    brst_ready = 1'b1;
    @(negedge clk);
    chk(brst_valid == 1'b1 && brst_addr == 16'h0104, "R11", "second burst before reset",
        brst_addr, 16'h0104);
    rst_n = 1'b0;
    #1;
    chk(req_ready == 1'b1 && brst_valid == 1'b0 && done == 1'b0, "R11", "state after reset",
        {req_ready, brst_valid, done}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    brst_ready = 1'b0;
    @(negedge clk);
    chk(brst_valid == 1'b0 && done == 1'b0, "R11", "no resumed burst", {brst_valid, done}, 0);

    // R5: word on a 32-bit region at a word boundary that is not a double-word one
    run_vec('{16'h0504, 3'd2, 2'd2, 1'b0, 3'd1, 3'd1, 3'd1}, 100);
    // R6: triple word off a word boundary on an 8-bit region
    run_vec('{16'h0031, 3'd4, 2'd0, 1'b1, 3'd0, 3'd0, 3'd0}, 101);

    finish_run();
  end

endmodule